// File: doc/BRIEF.md
# Serial EEPROM ID autoloader

This block fetches a device's subsystem identity from an external two-wire serial EEPROM once after reset. In the automatic mode it runs a single sequential read of the first five bytes. From the first four bytes it builds a 16-bit subsystem vendor ID and a 16-bit subsystem ID. The fifth byte is a checksum, and the identity registers take the values only when the checksum is correct. The block pulls the bus lines low or releases them and never drives them high.

In the software mode the block leaves the bus alone. Both identity registers then start at zero and software loads them through a small write port. Two strap inputs pick the mode. When the block has finished, `done_o` rises and stays high until the next reset. `err_o` reports a failed load.

Top module: `id_autoload`

## Requirements
- R1: The straps are sampled in the first cycle after reset. Both straps low selects the autoload mode. Any other combination, including strap A low with strap B high, selects the software mode.
- R2: An autoload issues START, byte 0xA0, byte 0x00, a repeated START, byte 0xA1, then reads five bytes MSB first. The first four bytes are acknowledged, the fifth gets a NACK, and a STOP follows. SCL is pulled low through `gp0_oe_o`. SDA is pulled low through `gp1_oe_o` and read on `gp1_i`, and it is sampled while SCL is high.
- R3: EEPROM byte 0 is the vendor ID bits 7:0 and byte 1 is bits 15:8. Byte 2 is the subsystem ID bits 7:0 and byte 3 is bits 15:8.
- R4: A load is valid when (0x55 + byte0 + byte1 + byte2 + byte3 + byte4) mod 256 equals 0. Only a valid load updates `svid_o` and `ssid_o`. This holds at the wrap-around, for example with all four ID bytes at 0xFF and a checksum of 0xAF.
- R5: On a checksum mismatch, both IDs stay 0x0000, `err_o` is 1 and `done_o` is 1.
- R6: If the device does not acknowledge its address, the block sends STOP and reads no data. Both IDs stay 0x0000, `err_o` and `done_o` go to 1, and both bus lines are released afterwards.
- R7: In autoload mode, `done_o` is 0 from reset until the STOP has completed. After that it stays at 1 until the next reset.
- R8: In software mode there is no bus activity and `err_o` stays 0. Both IDs read 0x0000 after reset, and `done_o` is 1 within three cycles after reset is released.
- R9: In software mode, a cycle with `wr_en_i` high writes `wr_data_i` into the vendor ID when `wr_sel_i` is 0, or into the subsystem ID when it is 1. The new value appears at the output after the next clock edge.
- R10: In autoload mode the write port has no effect, both while the load is running and after it has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_a_i | input | 1 | Mode strap A |
| strap_b_i | input | 1 | Mode strap B |
| gp0_oe_o | output | 1 | Pulls the SCL pin low when 1 |
| gp1_i | input | 1 | Level on the SDA pin |
| gp1_oe_o | output | 1 | Pulls the SDA pin low when 1 |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects the vendor ID, 1 the subsystem ID |
| wr_data_i | input | 16 | Write data |
| svid_o | output | 16 | Subsystem vendor ID |
| ssid_o | output | 16 | Subsystem ID |
| done_o | output | 1 | Load finished, held until reset |
| err_o | output | 1 | Checksum mismatch or missing device acknowledge |

## Verification
Internal faults show up in different places at the ports:
- A wrong step or bit counter in the sequencer changes the frame on the bus within one byte time. The EEPROM model in the bench sees a wrong address, a wrong read count or a missing final NACK.
- A wrong shift or byte slot does not show on the bus. It appears only when `done_o` rises, as swapped or shifted ID bytes, or as a false checksum error.
- A mode decoded wrongly shows within a few cycles, either as bus activity in the software mode or as writes that get through in the autoload mode.

// File: rtl/id_pkg.sv
package id_pkg;
  typedef enum logic [1:0] {
    CMD_START,
    CMD_STOP,
    CMD_WBIT,
    CMD_RBIT
  } bus_cmd_e;

  localparam int unsigned NUM_BYTES  = 5;
  localparam logic [7:0]  CKSUM_SEED = 8'h55;
  localparam logic [6:0]  DEV_ADDR   = 7'h50;
endpackage

// File: rtl/id_bit_phy.sv
module id_bit_phy
  import id_pkg::*;
#(
  parameter int unsigned DIV = 125
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     go_i,
  input  bus_cmd_e cmd_i,
  input  logic     bit_i,
  output logic     done_o,
  output logic     rx_o,
  input  logic     sda_i,
  output logic     scl_oe_o,
  output logic     sda_oe_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          busy_q, done_q, rx_q, scl_q, sda_q, bit_q;
  logic [1:0]    ph_q;
  logic [CW-1:0] cnt_q;
  bus_cmd_e      cmd_q;

  // line levels {scl, sda} for each quarter of a bit slot
  function automatic logic [1:0] lines(bus_cmd_e c, logic [1:0] p, logic b);
    logic [1:0] v;
    case (c)
      CMD_START: case (p)
        2'd0: v = 2'b01;
        2'd1: v = 2'b11;
        2'd2: v = 2'b10;
        default: v = 2'b00;
      endcase
      CMD_STOP: case (p)
        2'd0: v = 2'b00;
        2'd1: v = 2'b10;
        default: v = 2'b11;
      endcase
      CMD_WBIT: v = {(p == 2'd1) || (p == 2'd2), b};
      default:  v = {(p == 2'd1) || (p == 2'd2), 1'b1};
    endcase
    return v;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rx_q   <= 1'b1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      bit_q  <= 1'b0;
      ph_q   <= 2'd0;
      cnt_q  <= '0;
      cmd_q  <= CMD_STOP;
    end else begin
      done_q <= 1'b0;
      if (go_i && !busy_q) begin
        busy_q         <= 1'b1;
        ph_q           <= 2'd0;
        cnt_q          <= '0;
        cmd_q          <= cmd_i;
        bit_q          <= bit_i;
        {scl_q, sda_q} <= lines(cmd_i, 2'd0, bit_i);
      end else if (busy_q) begin
        if (cnt_q == CW'(DIV - 1)) begin
          cnt_q <= '0;
          if (ph_q == 2'd2 && cmd_q == CMD_RBIT) rx_q <= sda_i;
          if (ph_q == 2'd3) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            ph_q           <= ph_q + 2'd1;
            {scl_q, sda_q} <= lines(cmd_q, ph_q + 2'd1, bit_q);
          end
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign done_o   = done_q;
  assign rx_o     = rx_q;
  assign scl_oe_o = ~scl_q;
  assign sda_oe_o = ~sda_q;

  assert_go_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !busy_q);
endmodule

// File: rtl/id_load_seq.sv
module id_load_seq
  import id_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   strap_a_i,
  input  logic                   strap_b_i,
  output logic                   phy_go_o,
  output bus_cmd_e               phy_cmd_o,
  output logic                   phy_bit_o,
  input  logic                   phy_done_i,
  input  logic                   phy_rx_i,
  output logic                   sw_mode_o,
  output logic                   fin_o,
  output logic                   nack_o,
  output logic [NUM_BYTES*8-1:0] bytes_o
);
  localparam int unsigned STW      = 4;
  localparam int unsigned ST_DEVW  = 1;
  localparam int unsigned ST_RSTRT = 3;
  localparam int unsigned ST_DEVR  = 4;
  localparam int unsigned ST_RD0   = 5;
  localparam int unsigned ST_STOP  = ST_RD0 + NUM_BYTES;

  typedef enum logic [1:0] {SQ_STRAP, SQ_ISSUE, SQ_WAIT, SQ_END} sq_e;

  sq_e                    state_q;
  logic [STW-1:0]         step_q;
  logic [3:0]             bitn_q;
  logic [7:0]             sh_q;
  logic [NUM_BYTES*8-1:0] bytes_q;
  logic                   nack_q, sw_q, fin_q;

  logic       single, is_rd, last_bit;
  logic [7:0] tx_byte;

  always_comb begin
    single   = (step_q == '0) || (step_q == STW'(ST_RSTRT)) || (step_q == STW'(ST_STOP));
    is_rd    = (step_q >= STW'(ST_RD0)) && (step_q < STW'(ST_STOP));
    last_bit = (bitn_q == 4'd8);
    case (step_q)
      STW'(ST_DEVW): tx_byte = {DEV_ADDR, 1'b0};
      STW'(ST_DEVR): tx_byte = {DEV_ADDR, 1'b1};
      default:       tx_byte = 8'h00;
    endcase
    phy_bit_o = 1'b0;
    if (single) begin
      phy_cmd_o = (step_q == STW'(ST_STOP)) ? CMD_STOP : CMD_START;
    end else if (is_rd) begin
      phy_cmd_o = last_bit ? CMD_WBIT : CMD_RBIT;
      phy_bit_o = last_bit && (step_q == STW'(ST_STOP - 1));
    end else begin
      phy_cmd_o = last_bit ? CMD_RBIT : CMD_WBIT;
      phy_bit_o = tx_byte[3'd7 - bitn_q[2:0]];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_STRAP;
      step_q  <= '0;
      bitn_q  <= '0;
      sh_q    <= '0;
      bytes_q <= '0;
      nack_q  <= 1'b0;
      sw_q    <= 1'b0;
      fin_q   <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      case (state_q)
        SQ_STRAP: begin
          if (!strap_a_i && !strap_b_i) begin
            state_q <= SQ_ISSUE;
          end else begin
            sw_q    <= 1'b1;
            state_q <= SQ_END;
          end
        end
        SQ_ISSUE: state_q <= SQ_WAIT;
        SQ_WAIT: if (phy_done_i) begin
          state_q <= SQ_ISSUE;
          if (single) begin
            if (step_q == STW'(ST_STOP)) begin
              state_q <= SQ_END;
              fin_q   <= 1'b1;
            end else begin
              step_q <= step_q + STW'(1);
            end
          end else if (!last_bit) begin
            if (is_rd) sh_q <= {sh_q[6:0], phy_rx_i};
            bitn_q <= bitn_q + 4'd1;
          end else begin
            bitn_q <= '0;
            if (!is_rd && phy_rx_i) begin
              nack_q <= 1'b1;
              step_q <= STW'(ST_STOP);
            end else begin
              for (int k = 0; k < NUM_BYTES; k++)
                if (step_q == STW'(ST_RD0 + k)) bytes_q[k*8 +: 8] <= sh_q;
              step_q <= step_q + STW'(1);
            end
          end
        end
        default: state_q <= SQ_END;
      endcase
    end
  end

  assign phy_go_o  = (state_q == SQ_ISSUE);
  assign sw_mode_o = sw_q;
  assign fin_o     = fin_q;
  assign nack_o    = nack_q;
  assign bytes_o   = bytes_q;

  assert_end_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == SQ_END |=> state_q == SQ_END);
endmodule

// File: rtl/id_regs.sv
module id_regs
  import id_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sw_mode_i,
  input  logic                   fin_i,
  input  logic                   nack_i,
  input  logic [NUM_BYTES*8-1:0] bytes_i,
  input  logic                   wr_en_i,
  input  logic                   wr_sel_i,
  input  logic [15:0]            wr_data_i,
  output logic [15:0]            svid_o,
  output logic [15:0]            ssid_o,
  output logic                   done_o,
  output logic                   err_o
);
  logic [15:0] svid_q, ssid_q;
  logic        done_q, err_q;
  logic [7:0]  sum;

  always_comb begin
    sum = CKSUM_SEED;
    for (int k = 0; k < NUM_BYTES; k++) sum = sum + bytes_i[k*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      svid_q <= '0;
      ssid_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (fin_i) begin
      done_q <= 1'b1;
      if (!nack_i && sum == 8'h00) begin
        svid_q <= {bytes_i[15:8], bytes_i[7:0]};
        ssid_q <= {bytes_i[31:24], bytes_i[23:16]};
      end else begin
        err_q <= 1'b1;
      end
    end else if (sw_mode_i) begin
      done_q <= 1'b1;
      if (wr_en_i) begin
        if (wr_sel_i) ssid_q <= wr_data_i;
        else          svid_q <= wr_data_i;
      end
    end
  end

  assign svid_o = svid_q;
  assign ssid_o = ssid_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  assert_err_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (svid_q == 16'h0 && ssid_q == 16'h0));
  assert_ro_autoload_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_mode_i && !fin_i) |=> ($stable(svid_q) && $stable(ssid_q)));
endmodule

// File: rtl/id_autoload.sv
module id_autoload
  import id_pkg::*;
#(
  parameter int unsigned DIV = 125
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        strap_a_i,
  input  logic        strap_b_i,
  output logic        gp0_oe_o,
  input  logic        gp1_i,
  output logic        gp1_oe_o,
  input  logic        wr_en_i,
  input  logic        wr_sel_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] svid_o,
  output logic [15:0] ssid_o,
  output logic        done_o,
  output logic        err_o
);
  logic                   go, pbit, pdone, prx, sw_mode, fin, nack;
  bus_cmd_e               pcmd;
  logic [NUM_BYTES*8-1:0] bytes;

  id_bit_phy #(.DIV(DIV)) u_phy (
    .clk_i, .rst_ni,
    .go_i(go), .cmd_i(pcmd), .bit_i(pbit),
    .done_o(pdone), .rx_o(prx),
    .sda_i(gp1_i), .scl_oe_o(gp0_oe_o), .sda_oe_o(gp1_oe_o)
  );

  id_load_seq u_seq (
    .clk_i, .rst_ni,
    .strap_a_i, .strap_b_i,
    .phy_go_o(go), .phy_cmd_o(pcmd), .phy_bit_o(pbit),
    .phy_done_i(pdone), .phy_rx_i(prx),
    .sw_mode_o(sw_mode), .fin_o(fin), .nack_o(nack), .bytes_o(bytes)
  );

  id_regs u_regs (
    .clk_i, .rst_ni,
    .sw_mode_i(sw_mode), .fin_i(fin), .nack_i(nack), .bytes_i(bytes),
    .wr_en_i, .wr_sel_i, .wr_data_i,
    .svid_o, .ssid_o, .done_o, .err_o
  );

  assert_sw_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_mode |-> (!gp0_oe_o && !gp1_oe_o && !err_o));
  assert_done_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
endmodule

// File: tb/id_autoload_bench.sv
module id_autoload_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strap_a = 1'b0, strap_b = 1'b0;
  logic        gp0_oe, gp1_oe, gp1_in;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] svid, ssid;
  logic        done, err;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // two-wire bus with an EEPROM model
  logic       slv_low = 1'b0;
  logic       scl_w, sda_w;
  assign scl_w  = ~gp0_oe;
  assign sda_w  = ~(gp1_oe | slv_low);
  assign gp1_in = sda_w;

  id_autoload #(.DIV(4)) u_id_autoload (
    .clk_i(clk), .rst_ni,
    .strap_a_i(strap_a), .strap_b_i(strap_b),
    .gp0_oe_o(gp0_oe), .gp1_i(gp1_in), .gp1_oe_o(gp1_oe),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .svid_o(svid), .ssid_o(ssid), .done_o(done), .err_o(err)
  );

  typedef enum logic [2:0] {M_IDLE, M_ADDR, M_WADDR, M_HOLD, M_TX} mst_e;
  mst_e       m_st = M_IDLE;
  logic [7:0] mem [0:15];
  logic [7:0] m_sh = '0, m_ptr = '0, waddr_seen = 8'hFF;
  logic [3:0] m_bc = '0;
  logic       m_ack = 1'b0, m_nack = 1'b0, last_nack = 1'b0, present = 1'b1;
  logic       prev_scl = 1'b1, prev_sda = 1'b1, bus_seen = 1'b0;
  int         rd_cnt = 0, stop_cnt = 0;

  always @(posedge clk) begin
    prev_scl <= scl_w;
    prev_sda <= sda_w;
    if (gp0_oe || gp1_oe) bus_seen <= 1'b1;
    if (!rst_ni) begin
      m_st <= M_IDLE; slv_low <= 1'b0; m_bc <= '0; m_ack <= 1'b0;
      rd_cnt <= 0; stop_cnt <= 0; last_nack <= 1'b0; waddr_seen <= 8'hFF;
      bus_seen <= 1'b0;
    end else if (scl_w && prev_scl && prev_sda && !sda_w) begin
      m_st <= M_ADDR; m_bc <= '0; m_ack <= 1'b0; slv_low <= 1'b0;
    end else if (scl_w && prev_scl && !prev_sda && sda_w) begin
      m_st <= M_IDLE; slv_low <= 1'b0; stop_cnt <= stop_cnt + 1;
    end else if (scl_w && !prev_scl) begin
      if ((m_st == M_ADDR || m_st == M_WADDR) && m_bc < 8) begin
        m_sh <= {m_sh[6:0], sda_w}; m_bc <= m_bc + 4'd1;
      end else if (m_st == M_TX) begin
        if (m_bc < 8) m_bc <= m_bc + 4'd1;
        else if (m_bc == 8) begin m_nack <= sda_w; m_bc <= 4'd9; end
      end
    end else if (!scl_w && prev_scl) begin
      if (m_st == M_ADDR || m_st == M_WADDR) begin
        if (m_bc == 8 && !m_ack) begin
          if (present && (m_st == M_WADDR || m_sh[7:1] == 7'h50)) begin
            slv_low <= 1'b1; m_ack <= 1'b1;
          end else m_st <= M_IDLE;
        end else if (m_ack) begin
          m_ack <= 1'b0; slv_low <= 1'b0; m_bc <= '0;
          if (m_st == M_WADDR) begin
            m_ptr <= m_sh; waddr_seen <= m_sh; m_st <= M_HOLD;
          end else if (m_sh[0]) begin
            m_st <= M_TX; slv_low <= ~mem[m_ptr[3:0]][7];
          end else m_st <= M_WADDR;
        end
      end else if (m_st == M_TX) begin
        if (m_bc < 8) slv_low <= ~mem[m_ptr[3:0]][3'd7 - m_bc[2:0]];
        else if (m_bc == 8) slv_low <= 1'b0;
        else begin
          rd_cnt <= rd_cnt + 1;
          if (!m_nack) begin
            m_ptr <= m_ptr + 8'd1; m_bc <= '0;
            slv_low <= ~mem[m_ptr[3:0] + 4'd1][7];
          end else begin
            m_st <= M_IDLE; slv_low <= 1'b0; last_nack <= 1'b1;
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard: expected {err, ssid, svid} compared on the rise of done
  logic [32:0] exp_q [$];
  string       tag_q [$];
  logic        prev_done = 1'b0;

  always @(negedge clk) begin
    prev_done <= done;
    if (rst_ni && done && !prev_done) begin
      if (exp_q.size() == 0) check(0, "R7 unexpected done", 32'd1, 32'd0);
      else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({err, ssid, svid} == e, t, {15'd0, err, ssid, svid}, {15'd0, e[32:16]});
        check(svid == e[15:0], t, {16'd0, svid}, {16'd0, e[15:0]});
      end
    end
  end

  task automatic start_run(input logic sa, input logic sb, input logic dev,
                           input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input logic [7:0] b3,
                           input logic [7:0] b4, input logic [32:0] exp, input string tag);
    @(negedge clk);
    rst_ni = 1'b0;
    strap_a = sa; strap_b = sb; present = dev;
    for (int i = 0; i < 16; i++) mem[i] = 8'hC3 ^ 8'(i);
    mem[0] = b0; mem[1] = b1; mem[2] = b2; mem[3] = b3; mem[4] = b4;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && err == 1'b0 && svid == 16'h0 && ssid == 16'h0,
          "R7 R8 reset state", {14'd0, done, err, svid}, 32'd0);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rst_ni = 1'b1;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    check(done == 1'b1, tag, {31'd0, done}, 32'd1);
    repeat (2) @(negedge clk);
  endtask

  task automatic write_reg(input logic sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] cks(input logic [7:0] a, input logic [7:0] b,
                                     input logic [7:0] c, input logic [7:0] d);
    return 8'h00 - (8'h55 + a + b + c + d);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R7 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 R2 R3 R4: good autoload, writes during load must be ignored (R10)
    start_run(0, 0, 1, 8'h2B, 8'h1A, 8'h4D, 8'h3C, cks(8'h2B, 8'h1A, 8'h4D, 8'h3C),
              {1'b0, 16'h3C4D, 16'h1A2B}, "R3 R4 autoload ids");
    repeat (30) @(negedge clk);
    check(done == 1'b0, "R7 done low during load", {31'd0, done}, 32'd0);
    write_reg(1'b0, 16'hBEEF);
    write_reg(1'b1, 16'hCAFE);
    wait_done("R7 load finishes");
    check(waddr_seen == 8'h00, "R2 word address", {24'd0, waddr_seen}, 32'd0);
    check(rd_cnt == 5, "R2 bytes read", rd_cnt, 32'd5);
    check(last_nack == 1'b1, "R2 final nack", {31'd0, last_nack}, 32'd1);
    check(stop_cnt == 1, "R2 stop sent", stop_cnt, 32'd1);
    check(!gp0_oe && !gp1_oe, "R2 bus released", {30'd0, gp0_oe, gp1_oe}, 32'd0);
    // R10: writes after the load
    write_reg(1'b0, 16'h5555);
    write_reg(1'b1, 16'hAAAA);
    @(negedge clk);
    check(svid == 16'h1A2B && ssid == 16'h3C4D, "R10 writes ignored in autoload",
          {ssid, svid}, 32'h3C4D1A2B);
    check(done == 1'b1, "R7 done holds", {31'd0, done}, 32'd1);

    // R4 wrap-around boundary
    start_run(0, 0, 1, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hAF,
              {1'b0, 16'hFFFF, 16'hFFFF}, "R4 checksum wrap");
    wait_done("R4 load finishes");

    // R3 distinct byte order
    start_run(0, 0, 1, 8'h01, 8'h80, 8'h7E, 8'h00, cks(8'h01, 8'h80, 8'h7E, 8'h00),
              {1'b0, 16'h007E, 16'h8001}, "R3 byte placement");
    wait_done("R3 load finishes");

    // R5 checksum mismatch
    start_run(0, 0, 1, 8'h11, 8'h22, 8'h33, 8'h44, cks(8'h11, 8'h22, 8'h33, 8'h44) ^ 8'h01,
              {1'b1, 16'h0000, 16'h0000}, "R5 mismatch keeps zero");
    wait_done("R5 load finishes");
    check(rd_cnt == 5, "R5 full read before reject", rd_cnt, 32'd5);

    // R6 no device
    start_run(0, 0, 0, 8'h11, 8'h22, 8'h33, 8'h44, cks(8'h11, 8'h22, 8'h33, 8'h44),
              {1'b1, 16'h0000, 16'h0000}, "R6 missing device");
    wait_done("R6 load finishes");
    check(rd_cnt == 0, "R6 no data read", rd_cnt, 32'd0);
    check(stop_cnt == 1, "R6 stop sent", stop_cnt, 32'd1);
    check(!gp0_oe && !gp1_oe, "R6 bus released", {30'd0, gp0_oe, gp1_oe}, 32'd0);

    // R1 R8 R9: software mode, strap A low / strap B high
    start_run(0, 1, 1, 8'h2B, 8'h1A, 8'h4D, 8'h3C, cks(8'h2B, 8'h1A, 8'h4D, 8'h3C),
              {1'b0, 16'h0000, 16'h0000}, "R8 software mode zero");
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R8 done quickly", {31'd0, done}, 32'd1);
    write_reg(1'b0, 16'h1234);
    check(svid == 16'h1234 && ssid == 16'h0, "R9 vendor write", {ssid, svid}, 32'h00001234);
    write_reg(1'b1, 16'hABCD);
    check(svid == 16'h1234 && ssid == 16'hABCD, "R9 subsystem write", {ssid, svid}, 32'hABCD1234);
    repeat (200) @(negedge clk);
    check(bus_seen == 1'b0 && err == 1'b0, "R8 no bus activity", {30'd0, bus_seen, err}, 32'd0);

    // R1: other strap combination also software mode
    start_run(1, 1, 1, 8'h2B, 8'h1A, 8'h4D, 8'h3C, cks(8'h2B, 8'h1A, 8'h4D, 8'h3C),
              {1'b0, 16'h0000, 16'h0000}, "R1 straps high software");
    repeat (3) @(negedge clk);
    write_reg(1'b1, 16'h0F0F);
    check(ssid == 16'h0F0F, "R1 R9 writable", {16'd0, ssid}, 32'h0F0F);
    repeat (200) @(negedge clk);
    check(bus_seen == 1'b0, "R1 no load", {31'd0, bus_seen}, 32'd0);

    check(exp_q.size() == 0, "R7 all loads reported", exp_q.size(), 32'd0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule